// File: doc/BRIEF.md
# GF(3^97) Cubing Unit with Feedback

This block raises an element of GF(3^97) to the third power, with the field built as GF(3)[x] modulo x^97 + x^12 + 2. An element is held as 97 base-three digits of two bits each, 194 bits in all. Digit i is stored in bits [2i+1:2i] and encoded as 00 for 0, 01 for 1 and 10 for 2. In characteristic three the cube of a polynomial is sum(a_i x^(3i)). The unit reduces each term of degree 97 or more with x^97 = 2x^12 + 1, applying the rule again until the degree is below 97. For this trinomial, each result digit is then a sum of at most three input digits.

The operand is loaded into an internal register, and that register drives the result output. A run of k cubings is then requested. Each cubing takes one clock, and the result is written back into the same register, so the chains of cubings that Fermat-style inversion needs never pass through memory. The last cubing of a run can be written negated, which multiplies every digit by two. A done pulse marks the end of each run.

Top module: `gf3_cube_unit`

## Requirements
- R1: After reset, result_o is zero and busy_o and done_o are low.
- R2: With load_i high and busy_o low, result_o shows operand_i after one clock edge. Any digit coded 11 in operand_i is stored as 00.
- R3: One cubing replaces the register with a^3 mod x^97+x^12+2. This gives result digit 0 = a93+a89+a0, digit 1 = a65+2a61, digit 2 = a33, digit 3 = a94+a90+a1, digit 94 = a96+a92+a88, digit 95 = a64+2a60 and digit 96 = a32, all taken mod 3.
- R4: When start_i is accepted with count_i = k > 0, exactly k cubings run back to back, one per clock, and the final value is a^(3^k).
- R5: busy_o is high for the k cycles of the run. done_o is high for exactly one cycle, and that cycle starts at edge k after the start edge, when the final value is already on result_o.
- R6: When neg_i is high at start, the last cubing of the run is written negated, so the final value is -(a^(3^k)).
- R7: A start with count_i = 0 leaves the register unchanged, including when neg_i is high, and raises done_o in the next cycle.
- R8: While busy_o is high, load_i and start_i are ignored. While the unit is idle and load_i is low, result_o holds its value.
- R9: The code 11 never appears in any digit of result_o.
- R10: A run of 97 cubings returns the original operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load operand_i into the register (idle only) |
| operand_i | input | 194 | Operand, 97 digits of two bits |
| start_i | input | 1 | Start a run of cubings (idle only) |
| count_i | input | 8 | Number of cubings in the run |
| neg_i | input | 1 | Negate the final cubing of the run |
| result_o | output | 194 | Registered field element |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
The assertions check on every cycle that no digit of the output is ever coded 11 and that an idle register only changes on a load. They also check that a load captures the cleaned operand, that a run counts down by one each cycle, and that done follows the last cubing. They cannot show that the arithmetic is right. The bench does that by comparing each run with a cube built from two schoolbook field multiplications, and by checking the listed low and high digits on their own. Only the bench scenarios can show negation of the last step, the zero-length run, commands that are ignored during a run, and the return to the operand after 97 cubings.

// File: rtl/gf3_cube_pkg.sv
package gf3_cube_pkg;

  typedef logic [1:0] digit_t;

  localparam digit_t D_ZERO = 2'b00;
  localparam digit_t D_ONE  = 2'b01;
  localparam digit_t D_TWO  = 2'b10;

  // map the unused code to zero
  function automatic digit_t gf3_clean(digit_t d);
    return (d == 2'b11) ? D_ZERO : d;
  endfunction

  function automatic digit_t gf3_add(digit_t a, digit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // 2*d == -d: swap the two code bits
  function automatic digit_t gf3_neg(digit_t d);
    return {d[0], d[1]};
  endfunction

endpackage

// File: rtl/gf3_cube_net.sv
module gf3_cube_net
  import gf3_cube_pkg::*;
#(
  parameter int M = 97,
  parameter int K = 12
) (
  input  logic [2*M-1:0] a_i,
  output logic [2*M-1:0] cube_o
);

  localparam int TOP = 3 * (M - 1);

  always_comb begin
    digit_t wide [0:TOP];
    for (int d = 0; d <= TOP; d++) wide[d] = D_ZERO;
    for (int i = 0; i < M; i++) wide[3*i] = a_i[2*i +: 2];
    // x^M = 2x^K + 1; descending order folds the carried terms again
    for (int d = TOP; d >= M; d--) begin
      wide[d-M+K] = gf3_add(wide[d-M+K], gf3_neg(wide[d]));
      wide[d-M]   = gf3_add(wide[d-M], wide[d]);
    end
    for (int j = 0; j < M; j++) cube_o[2*j +: 2] = wide[j];
  end

  generate
    if (M == 97 && K == 12) begin : g_chk
      always_comb begin
        assert_digit2_R3: assert (cube_o[5:4] == a_i[67:66]);
        assert_digit96_R3: assert (cube_o[193:192] == a_i[65:64]);
      end
    end
  endgenerate

endmodule

// File: rtl/gf3_negate.sv
module gf3_negate
  import gf3_cube_pkg::*;
#(
  parameter int M = 97
) (
  input  logic           neg_i,
  input  logic [2*M-1:0] a_i,
  output logic [2*M-1:0] y_o
);

  generate
    for (genvar g = 0; g < M; g++) begin : g_dig
      assign y_o[2*g +: 2] = neg_i ? gf3_neg(a_i[2*g +: 2]) : a_i[2*g +: 2];
    end
  endgenerate

endmodule

// File: rtl/cube_run_ctrl.sv
module cube_run_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          neg_i,
  output logic          step_o,
  output logic          last_o,
  output logic          neg_o,
  output logic          busy_o,
  output logic          done_o
);

  logic [CW-1:0] rem_q;
  logic          busy_q, neg_q, done_q;
  logic          accept;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      rem_q  <= count_i;
      busy_q <= (count_i != '0);
      neg_q  <= neg_i;
      done_q <= (count_i == '0);
    end else if (busy_q) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == {{(CW-1){1'b0}}, 1'b1}) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign step_o = busy_q;
  assign last_o = busy_q && (rem_q == {{(CW-1){1'b0}}, 1'b1});
  assign neg_o  = neg_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_countdown_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && rem_q == $past(rem_q) - 1'b1));

  assert_done_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_q && !busy_q));

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

endmodule

// File: rtl/gf3_cube_unit.sv
module gf3_cube_unit
  import gf3_cube_pkg::*;
#(
  parameter int M  = 97,
  parameter int K  = 12,
  parameter int CW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [2*M-1:0] operand_i,
  input  logic           start_i,
  input  logic [CW-1:0]  count_i,
  input  logic           neg_i,
  output logic [2*M-1:0] result_o,
  output logic           busy_o,
  output logic           done_o
);

  localparam int W = 2 * M;

  logic [W-1:0] acc_q, clean, cube, next_val;
  logic         step, last, neg_run, busy;

  generate
    for (genvar g = 0; g < M; g++) begin : g_clean
      assign clean[2*g +: 2] = gf3_clean(operand_i[2*g +: 2]);
    end
  endgenerate

  cube_run_ctrl #(.CW(CW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .count_i(count_i),
    .neg_i  (neg_i),
    .step_o (step),
    .last_o (last),
    .neg_o  (neg_run),
    .busy_o (busy),
    .done_o (done_o)
  );

  gf3_cube_net #(.M(M), .K(K)) u_cube (
    .a_i   (acc_q),
    .cube_o(cube)
  );

  gf3_negate #(.M(M)) u_neg (
    .neg_i(last && neg_run),
    .a_i  (cube),
    .y_o  (next_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (load_i && !busy) acc_q <= clean;
    else if (step)          acc_q <= next_val;
  end

  assign result_o = acc_q;
  assign busy_o   = busy;

  logic bad_digit;
  always_comb begin
    bad_digit = 1'b0;
    for (int i = 0; i < M; i++)
      if (result_o[2*i +: 2] == 2'b11) bad_digit = 1'b1;
  end

  assert_no_code3_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_digit);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> (result_o == $past(clean)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> $stable(result_o));

endmodule

// File: tb/gf3_cube_unit_test.sv
`timescale 1ns/1ps
module gf3_cube_unit_test;

  localparam int M  = 97;
  localparam int W  = 2 * M;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [W-1:0]  operand_i = '0;
  logic          start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          neg_i = 1'b0;
  logic [W-1:0]  result_o;
  logic          busy_o, done_o;

  always #4 clk_i = ~clk_i;

  gf3_cube_unit #(.M(M), .K(12), .CW(CW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .operand_i(operand_i),
    .start_i(start_i), .count_i(count_i), .neg_i(neg_i),
    .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [W-1:0] model = '0;

  logic [W-1:0] val_q[$];
  int           cyc_q[$];
  string        tag_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int dig(input logic [W-1:0] v, input int i);
    return (v[2*i +: 2] == 2'b11) ? 0 : int'(v[2*i +: 2]);
  endfunction

  function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b);
    int p [0:2*M-2];
    logic [W-1:0] r;
    for (int i = 0; i <= 2*M-2; i++) p[i] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++) p[i+j] += dig(a, i) * dig(b, j);
    for (int d = 2*M-2; d >= M; d--) begin
      int c;
      c = p[d] % 3;
      p[d-M+12] += 2 * c;
      p[d-M] += c;
    end
    r = '0;
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(p[i] % 3);
    return r;
  endfunction

  function automatic logic [W-1:0] cube_ref(input logic [W-1:0] a);
    return mulmod(mulmod(a, a), a);
  endfunction

  function automatic logic [W-1:0] neg_ref(input logic [W-1:0] a);
    logic [W-1:0] r;
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'((3 - dig(a, i)) % 3);
    return r;
  endfunction

  function automatic logic [W-1:0] clean_ref(input logic [W-1:0] a);
    logic [W-1:0] r;
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'(dig(a, i));
    return r;
  endfunction

  function automatic logic [W-1:0] gen(input int seed);
    logic [W-1:0] r;
    for (int i = 0; i < M; i++) r[2*i +: 2] = 2'((i * seed * 7 + i * i + seed) % 3);
    return r;
  endfunction

  function automatic bit has_code3(input logic [W-1:0] v);
    for (int i = 0; i < M; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  // monitor: pops expected run results when done_o pulses
  bit done_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_prev)
        check(!done_o, "R5", "done longer than one cycle", W'(done_o), '0);
      if (done_o) begin
        if (val_q.size() == 0) begin
          check(1'b0, "R5", "unexpected done", result_o, '0);
        end else begin
          logic [W-1:0] ev;
          int ec;
          string et;
          ev = val_q.pop_front();
          ec = cyc_q.pop_front();
          et = tag_q.pop_front();
          check(result_o == ev, et, "run result", result_o, ev);
          check(cyc == ec, "R5", "done cycle", W'(cyc), W'(ec));
          check(!has_code3(result_o), "R9", "code 11 in result", result_o, '0);
        end
      end
      done_prev = done_o;
    end
  end

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk_i);
    load_i = 1'b1;
    operand_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
    model = clean_ref(v);
    check(result_o == model, "R2", "load", result_o, model);
  endtask

  // driver: computes expected value, pushes it, starts the run
  task automatic do_run(input int k, input bit ng, input string tag);
    logic [W-1:0] e;
    e = model;
    for (int i = 0; i < k; i++) e = cube_ref(e);
    if (ng && k > 0) e = neg_ref(e);
    model = e;
    @(negedge clk_i);
    val_q.push_back(e);
    cyc_q.push_back(cyc + 1 + k);
    tag_q.push_back(tag);
    start_i = 1'b1;
    count_i = CW'(k);
    neg_i = ng;
    @(negedge clk_i);
    start_i = 1'b0;
    neg_i = 1'b0;
    if (k > 1) check(busy_o, "R5", "busy during run", W'(busy_o), W'(1));
    while (val_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [W-1:0] v, prev, r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(result_o == '0, "R1", "reset result", result_o, '0);
    check(!busy_o && !done_o, "R1", "reset flags", W'({busy_o, done_o}), '0);

    // R2/R9 load with invalid codes
    v = gen(1);
    v[11:10] = 2'b11;
    v[193:192] = 2'b11;
    do_load(v);
    check(!has_code3(result_o), "R9", "code 11 after load", result_o, '0);

    // R3 single cube plus explicit digits
    prev = model;
    do_run(1, 1'b0, "R3");
    r = result_o;
    check(dig(r,0) == (dig(prev,93)+dig(prev,89)+dig(prev,0))%3, "R3", "digit0", W'(dig(r,0)), '0);
    check(dig(r,1) == (dig(prev,65)+2*dig(prev,61))%3, "R3", "digit1", W'(dig(r,1)), '0);
    check(dig(r,2) == dig(prev,33), "R3", "digit2", W'(dig(r,2)), W'(dig(prev,33)));
    check(dig(r,3) == (dig(prev,94)+dig(prev,90)+dig(prev,1))%3, "R3", "digit3", W'(dig(r,3)), '0);
    check(dig(r,94) == (dig(prev,96)+dig(prev,92)+dig(prev,88))%3, "R3", "digit94", W'(dig(r,94)), '0);
    check(dig(r,95) == (dig(prev,64)+2*dig(prev,60))%3, "R3", "digit95", W'(dig(r,95)), '0);
    check(dig(r,96) == dig(prev,32), "R3", "digit96", W'(dig(r,96)), W'(dig(prev,32)));

    // R3 cube of x, and of a high monomial
    v = '0; v[3:2] = 2'b01;
    do_load(v);
    do_run(1, 1'b0, "R3");
    v = '0; v[2*80 +: 2] = 2'b10;
    do_load(v);
    do_run(1, 1'b0, "R3");

    // R4 chain
    do_load(gen(2));
    do_run(5, 1'b0, "R4");

    // R6 negated final step
    do_run(1, 1'b1, "R6");
    do_run(3, 1'b1, "R6");

    // R7 zero-length run with negate requested
    do_run(0, 1'b1, "R7");

    // R10 Frobenius period
    do_load(gen(3));
    do_run(97, 1'b0, "R10");
    check(result_o == clean_ref(gen(3)), "R10", "return to operand", result_o, clean_ref(gen(3)));

    // R8 commands during a run are ignored
    do_load(gen(4));
    prev = model;
    v = prev;
    for (int i = 0; i < 4; i++) v = cube_ref(v);
    model = v;
    @(negedge clk_i);
    val_q.push_back(v);
    cyc_q.push_back(cyc + 5);
    tag_q.push_back("R8");
    start_i = 1'b1; count_i = CW'(4);
    @(negedge clk_i);
    start_i = 1'b1; count_i = CW'(1); neg_i = 1'b1;
    load_i = 1'b1; operand_i = gen(5);
    @(negedge clk_i);
    start_i = 1'b0; load_i = 1'b0; neg_i = 1'b0;
    while (val_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    check(result_o == model, "R8", "idle hold", result_o, model);

    report();
  end

endmodule